// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is a small general-purpose I/O port with eight pins, reached through a simple memory-mapped register bus over a 4 KB window. Each pin is an output or an input, as a direction register sets it. Output pins drive the level held in the data register. Input pins are reported high on the output vector, and each cycle the data register samples their external level. When an output level changes, a per-pin strobe pulses for one cycle.

Data accesses use the address as a bit mask. For any offset below 0x400, address bits [9:2] select the data bits that a read returns or a write may touch. Software can therefore change a chosen group of output pins in one store, with no read-modify-write. Next to the data path are interrupt configuration storage and a raw interrupt status. Software clears the raw status by writing ones, and it can be read masked. The window also holds pad-configuration shadow bytes and twelve fixed identification bytes. Edge or level detection is not part of the block: events come in as set pulses on a dedicated input.

Bus requests take one cycle. A read result appears on the registered read bus on the cycle after the request, and so does the error flag for an unmapped offset.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data, direction, interrupt configuration, raw status and pad registers are zero. In the same state `pinOut` is 0xFF, `pinChg`, `irq`, `busErr` and `busRdata` are 0.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2]. Every read result appears on `busRdata` on the cycle after the request and holds until the next read.
- R3: A write at an offset below 0x400 changes only the data bits whose address bit ([9:2], bit i at address bit i+2) and direction bit are both 1.
- R4: The direction register is at offset 0x400, read/write, and a 1 makes the pin an output. One cycle after the registers change, `pinOut` equals (data AND direction) OR (NOT direction).
- R5: `pinChg` is high for exactly one cycle, in the cycle where `pinOut` takes its new value, and only on the bits whose level changed.
- R6: Each cycle, a pin whose direction bit is 0 copies its `pinIn` level into its data bit. A data bit whose direction bit is 1 ignores `pinIn`.
- R7: The interrupt configuration registers are plain read/write bytes: sense at 0x404, both-edges at 0x408, event at 0x40C and mask at 0x410.
- R8: A high `intRaise` bit sets the matching raw status bit. Writing a 1 to a bit at 0x41C clears it, and a set in the same cycle takes precedence. The raw status reads at 0x414, and writes to 0x414 are ignored.
- R9: Offset 0x418 reads as raw status AND mask, and `irq` is the OR of those masked bits.
- R10: Eight pad-configuration bytes at 0x500, 0x504, up to 0x51C are plain read/write storage.
- R11: Offsets 0xFD0 to 0xFFC, one byte per word, read in order as 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R12: An access to an unmapped or misaligned register offset reads as zero, changes no register, and raises `busErr` for one cycle after the request. Offset 0x41C reads as zero without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset into the 4 KB window |
| busWdata | input | PINS | Write data |
| busRdata | output | PINS | Registered read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse after an unmapped access |
| pinIn | input | PINS | External pin levels |
| intRaise | input | PINS | Per-bit set pulses for the raw interrupt status |
| pinOut | output | PINS | Output pin levels, inputs shown as 1 |
| pinChg | output | PINS | One-cycle strobe per changed output bit |
| irq | output | 1 | OR of the masked interrupt status |

## Verification
The bench builds the block with its default PINS of 8. At that value the address mask uses all of bits [9:2] and the eight pad bytes and twelve identification bytes fill their full decode ranges. With this build, the tests can mix outputs and inputs in one nibble split and pick masks that touch only input bits, only output bits, or both. Those masks expose mix-ups between the address mask and the direction gate. Set-versus-clear collisions on the raw status and misaligned register offsets are also reachable at this width.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W   = 12;
  localparam int PAD_REGS = 8;
  localparam int ID_BYTES = 12;

  localparam logic [ADDR_W-1:0] OFF_DATA_END = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_DIR      = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_SENSE    = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_BOTH     = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_EVENT    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_MASK     = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RAW      = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_MASKED   = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_CLR      = 12'h41C;
  localparam logic [ADDR_W-1:0] OFF_PAD      = 12'h500;
  localparam logic [ADDR_W-1:0] OFF_ID       = 12'hFD0;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT,
    RD_MASK, RD_RAW, RD_MASKED, RD_PAD, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic       wrData;
    logic       wrDir;
    logic       wrSense;
    logic       wrBoth;
    logic       wrEvent;
    logic       wrMask;
    logic       wrClr;
    logic       wrPad;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [3:0] idx;
    logic       badAccess;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input logic [3:0] i);
    case (i)
      4'd4:    return 8'h61;
      4'd6:    return 8'h18;
      4'd7:    return 8'h01;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);
  logic aligned;
  logic inPad;
  logic inId;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign inPad   = aligned && (busAddr[ADDR_W-1:5] == OFF_PAD[ADDR_W-1:5]);
  assign inId    = aligned && (busAddr >= OFF_ID);

  always_comb begin
    strb = '0;
    if (busReq) begin
      strb.rdEn = !busWrite;
      if (busAddr < OFF_DATA_END) begin
        strb.rdSel  = RD_DATA;
        strb.wrData = busWrite;
      end else if (inPad) begin
        strb.rdSel = RD_PAD;
        strb.wrPad = busWrite;
        strb.idx   = {1'b0, busAddr[4:2]};
      end else if (inId) begin
        strb.rdSel = RD_ID;
        // window start has word index 4 in bits [5:2]; wrap to zero
        strb.idx   = busAddr[5:2] - 4'd4;
      end else begin
        unique case (busAddr)
          OFF_DIR:    begin strb.rdSel = RD_DIR;    strb.wrDir   = busWrite; end
          OFF_SENSE:  begin strb.rdSel = RD_SENSE;  strb.wrSense = busWrite; end
          OFF_BOTH:   begin strb.rdSel = RD_BOTH;   strb.wrBoth  = busWrite; end
          OFF_EVENT:  begin strb.rdSel = RD_EVENT;  strb.wrEvent = busWrite; end
          OFF_MASK:   begin strb.rdSel = RD_MASK;   strb.wrMask  = busWrite; end
          OFF_RAW:    strb.rdSel = RD_RAW;
          OFF_MASKED: strb.rdSel = RD_MASKED;
          OFF_CLR:    begin strb.rdSel = RD_NONE;   strb.wrClr   = busWrite; end
          default:    strb.badAccess = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strb,
  input  logic [PINS-1:0] addrMask,
  input  logic [PINS-1:0] busWdata,
  input  logic [PINS-1:0] pinIn,
  input  logic [PINS-1:0] intRaise,
  output logic [PINS-1:0] busRdata,
  output logic            busErr,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinChg,
  output logic            irq,
  output logic [PINS-1:0] dirQ,
  output logic [PINS-1:0] maskQ
);
  logic [PINS-1:0] dataQ, senseQ, bothQ, eventQ, rawQ;
  logic [PINS-1:0] padQ [PAD_REGS];
  logic [PINS-1:0] outVec, outQ, chgQ, rdNext, rdataQ, maskedStat;
  logic [7:0]      idVal;
  logic            errQ;

  // per-bit data: inputs follow the pin, outputs take gated bus writes
  for (genvar b = 0; b < PINS; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              dataQ[b] <= 1'b0;
      else if (!dirQ[b])                      dataQ[b] <= pinIn[b];
      else if (strb.wrData && addrMask[b])    dataQ[b] <= busWdata[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      senseQ <= '0;
      bothQ  <= '0;
      eventQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strb.wrDir)   dirQ   <= busWdata;
      if (strb.wrSense) senseQ <= busWdata;
      if (strb.wrBoth)  bothQ  <= busWdata;
      if (strb.wrEvent) eventQ <= busWdata;
      if (strb.wrMask)  maskQ  <= busWdata;
    end
  end

  // raw status: set pulses win over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= (rawQ & ~(strb.wrClr ? busWdata : '0)) | intRaise;
  end

  for (genvar p = 0; p < PAD_REGS; p++) begin : g_pad
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   padQ[p] <= '0;
      else if (strb.wrPad && strb.idx == 4'(p))    padQ[p] <= busWdata;
    end
  end

  // output vector, registered with a change strobe
  assign outVec = (dataQ & dirQ) | ~dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '1;
      chgQ <= '0;
    end else begin
      outQ <= outVec;
      chgQ <= outQ ^ outVec;
    end
  end

  assign maskedStat = rawQ & maskQ;
  assign idVal      = idByte(strb.idx);

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA:   rdNext = dataQ & addrMask;
      RD_DIR:    rdNext = dirQ;
      RD_SENSE:  rdNext = senseQ;
      RD_BOTH:   rdNext = bothQ;
      RD_EVENT:  rdNext = eventQ;
      RD_MASK:   rdNext = maskQ;
      RD_RAW:    rdNext = rawQ;
      RD_MASKED: rdNext = maskedStat;
      RD_PAD:    rdNext = padQ[strb.idx[2:0]];
      RD_ID:     rdNext = idVal[PINS-1:0];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else begin
      if (strb.rdEn) rdataQ <= rdNext;
      errQ <= strb.badAccess;
    end
  end

  assign busRdata = rdataQ;
  assign busErr   = errQ;
  assign pinOut   = outQ;
  assign pinChg   = chgQ;
  assign irq      = |maskedStat;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  output logic              busErr,
  input  logic [PINS-1:0]   pinIn,
  input  logic [PINS-1:0]   intRaise,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinChg,
  output logic              irq
);
  regStrobe_t      strb;
  logic [PINS-1:0] dirQ;
  logic [PINS-1:0] maskQ;

  gpio_port_ctrl u_ctrl (
    .busReq   (busReq),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  gpio_port_dp #(.PINS(PINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addrMask (busAddr[PINS+1:2]),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .intRaise (intRaise),
    .busRdata (busRdata),
    .busErr   (busErr),
    .pinOut   (pinOut),
    .pinChg   (pinChg),
    .irq      (irq),
    .dirQ     (dirQ),
    .maskQ    (maskQ)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            busReq,
  input logic            busWrite,
  input logic [PINS-1:0] busRdata,
  input logic            busErr,
  input logic [PINS-1:0] pinOut,
  input logic [PINS-1:0] pinChg,
  input logic            irq,
  input logic [PINS-1:0] dirQ,
  input logic [PINS-1:0] maskQ
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_chg_matches_R5: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (pinChg == (pinOut ^ $past(pinOut))));

  assert_inputs_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((~$past(dirQ) & ~pinOut) == '0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

  assert_err_after_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && busErr) |-> $past(busReq));

  assert_err_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !busReq) |=> !busErr);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(busReq && !busWrite)) |-> $stable(busRdata));
endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busRdata (busRdata),
  .busErr   (busErr),
  .pinOut   (pinOut),
  .pinChg   (pinChg),
  .irq      (irq),
  .dirQ     (dirQ),
  .maskQ    (maskQ)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int PINS = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busReq = 1'b0;
  logic            busWrite = 1'b0;
  logic [11:0]     busAddr = '0;
  logic [PINS-1:0] busWdata = '0;
  logic [PINS-1:0] busRdata;
  logic            busErr;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] intRaise = '0;
  logic [PINS-1:0] pinOut;
  logic [PINS-1:0] pinChg;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_port #(.PINS(PINS)) u_gpio_port (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .pinIn(pinIn), .intRaise(intRaise),
    .pinOut(pinOut), .pinChg(pinChg), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic busWr(input logic [11:0] a, input logic [7:0] v);
    busReq = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = v;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [7:0] v, output logic e);
    busReq = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busReq = 1'b0;
    v = busRdata; e = busErr;
  endtask

  task automatic testReset();
    logic [7:0] v; logic e;
    check("R1 pinOut", pinOut, 8'hFF);
    check("R1 pinChg", pinChg, 0);
    check("R1 irq", irq, 0);
    check("R1 rdata", busRdata, 0);
    busRd(12'h400, v, e); check("R1 dir", v, 0); check("R1 err", e, 0);
    busRd(12'h414, v, e); check("R1 raw", v, 0);
    busRd(12'h510, v, e); check("R1 pad", v, 0);
  endtask

  task automatic testOutputs();
    busWr(12'h400, 8'h0F);
    @(negedge clk);
    check("R4 pinOut after dir", pinOut, 8'hF0);
    check("R5 chg after dir", pinChg, 8'h0F);
    @(negedge clk);
    check("R5 chg one cycle", pinChg, 0);
    busWr(12'h3FC, 8'hA5);
    @(negedge clk);
    check("R4 pinOut full write", pinOut, 8'hF5);
    check("R5 chg full write", pinChg, 8'h05);
    busWr(12'h004, 8'h00);
    @(negedge clk);
    check("R3 single-bit mask write", pinOut, 8'hF4);
    check("R5 chg single bit", pinChg, 8'h01);
    busWr(12'h3C0, 8'hFF);
    @(negedge clk);
    check("R3 mask on input bits only", pinOut, 8'hF4);
    check("R5 no chg", pinChg, 0);
  endtask

  task automatic testInputs();
    logic [7:0] v; logic e;
    pinIn = 8'h30;
    @(negedge clk);
    busRd(12'h3C0, v, e); check("R2 read mask F0", v, 8'h30);
    busRd(12'h3FC, v, e); check("R2 read mask FF", v, 8'h34);
    busRd(12'h030, v, e); check("R2 read mask 0C", v, 8'h04);
    check("R2 rdata holds", busRdata, 8'h04);
    pinIn = 8'hCF;
    @(negedge clk);
    busRd(12'h3FC, v, e); check("R6 outputs ignore pinIn", v, 8'hC4);
    check("R6 pinOut unaffected", pinOut, 8'hF4);
    check("R4 inputs read high", pinOut & 8'hF0, 8'hF0);
  endtask

  task automatic testInterrupts();
    logic [7:0] v; logic e;
    busWr(12'h404, 8'h11); busWr(12'h408, 8'h22); busWr(12'h40C, 8'h33);
    busRd(12'h404, v, e); check("R7 sense", v, 8'h11);
    busRd(12'h408, v, e); check("R7 both", v, 8'h22);
    busRd(12'h40C, v, e); check("R7 event", v, 8'h33);
    intRaise = 8'h07;
    @(negedge clk);
    intRaise = 8'h00;
    check("R9 irq low mask zero", irq, 0);
    busWr(12'h410, 8'h05);
    busRd(12'h410, v, e); check("R7 mask", v, 8'h05);
    busRd(12'h414, v, e); check("R8 raw set", v, 8'h07);
    busRd(12'h418, v, e); check("R9 masked", v, 8'h05);
    check("R9 irq high", irq, 1);
    busWr(12'h414, 8'hFF);
    busRd(12'h414, v, e); check("R8 raw read-only", v, 8'h07);
    busWr(12'h41C, 8'h05);
    busRd(12'h414, v, e); check("R8 clear", v, 8'h02);
    busRd(12'h418, v, e); check("R9 masked after clear", v, 0);
    check("R9 irq low after clear", irq, 0);
    intRaise = 8'h08;
    busWr(12'h41C, 8'h0A);
    intRaise = 8'h00;
    busRd(12'h414, v, e); check("R8 set beats clear", v, 8'h08);
  endtask

  task automatic testPads();
    logic [7:0] v; logic e;
    for (int i = 0; i < 8; i++) busWr(12'h500 + 12'(4 * i), 8'(i * 8'h11 + 8'h3));
    for (int i = 0; i < 8; i++) begin
      busRd(12'h500 + 12'(4 * i), v, e);
      check("R10 pad readback", v, 8'(i * 8'h11 + 8'h3));
    end
  endtask

  task automatic testId();
    logic [7:0] v; logic e;
    logic [7:0] exp [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                             8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      busRd(12'hFD0 + 12'(4 * i), v, e);
      check("R11 id byte", v, exp[i]);
    end
  endtask

  task automatic testUnmapped();
    logic [7:0] v; logic e;
    busWr(12'h600, 8'hAA);
    check("R12 err on write", busErr, 1);
    @(negedge clk);
    check("R12 err one cycle", busErr, 0);
    busRd(12'h600, v, e); check("R12 read zero", v, 0); check("R12 err on read", e, 1);
    busRd(12'h420, v, e); check("R12 gap read zero", v, 0); check("R12 gap err", e, 1);
    busWr(12'h401, 8'hFF);
    busRd(12'h400, v, e); check("R12 misaligned ignored", v, 8'h0F);
    busRd(12'h41C, v, e); check("R12 clear reads zero", v, 0); check("R12 clear no err", e, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOutputs();
    testInputs();
    testInterrupts();
    testPads();
    testId();
    testUnmapped();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule